// File: doc/BRIEF.md
# Memory fault status capture

This block records the memory-management faults of a processor core. The translation and permission-check logic hands it a packed 64-bit fault word with a valid strobe and a flag that marks faults from instruction fetch. For a data-side fault it keeps the fault kind and domain in a status register and the faulting virtual address in an address register. It also sets a pending flag. The abort request to the core is raised only once the instruction that caused the fault has completed. The request stays up until the core accepts it.

Fetch-side faults only produce a one-cycle prefetch abort pulse. External bus errors that did not come from the translation unit raise the data abort but leave both registers untouched. Only the first recordable fault of an instruction is kept. Later faults cannot overwrite it until the abort has been accepted. Both registers are visible to the core as plain outputs.

Top module: `memfault_capture`

## Requirements
- R1: While reset is asserted and after reset is released, the status output is 0, the address output is 0, abort_pending is 0, abort_req is 0 and prefetch_abort is 0.
- R2: The fault word carries the kind in bits 3:0, the domain in bits 7:4 and the virtual address in bits 63:32. A data fault (flt_fetch low) of kind 1, 2 or 4 to 15 that arrives while nothing is pending sets fault_status to word[7:0] and fault_addr to word[63:32] in the next cycle.
- R3: A data fault of kind 3 (external error outside the translation unit) leaves fault_status and fault_addr unchanged. It still sets abort_pending in the next cycle.
- R4: A fault with flt_fetch high never changes fault_status, fault_addr or abort_pending. It drives prefetch_abort high for exactly the next cycle.
- R5: A strobe with kind 0 and flt_fetch low has no effect on any output.
- R6: Any data fault of kind other than 0 sets abort_pending. abort_req rises in the cycle after the first cycle, at or after the fault cycle, in which insn_done is high. It never rises before that.
- R7: While abort_pending is high and the abort has not been accepted in the same cycle, further data faults leave fault_status and fault_addr unchanged.
- R8: abort_ack in a cycle with abort_req high clears abort_req and abort_pending in the next cycle, unless a new data fault arrives in that same cycle. In that case the new fault is handled as if nothing had been pending. abort_ack while abort_req is low has no effect.
- R9: Bits 31:8 of the fault word have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flt_valid | input | 1 | Fault word is valid this cycle |
| flt_word | input | 64 | Packed fault: kind 3:0, domain 7:4, address 63:32 |
| flt_fetch | input | 1 | Fault came from instruction fetch |
| insn_done | input | 1 | The current instruction completes this cycle |
| abort_ack | input | 1 | Core accepts the data abort |
| abort_pending | output | 1 | A data fault is waiting to be taken |
| abort_req | output | 1 | Data abort request to the core |
| prefetch_abort | output | 1 | One-cycle prefetch abort pulse |
| fault_status | output | 8 | Recorded domain (7:4) and kind (3:0) |
| fault_addr | output | 32 | Recorded faulting virtual address |

## Verification
The assertions check the following on every cycle:
- the register lock while a fault is pending;
- that external errors and fetch faults never write the registers;
- the one-cycle prefetch pulse;
- that a request only exists alongside a pending fault and only after an instruction end;
- the clearing on acceptance.

Other behaviours need the bench's scenarios. These include the exact field mapping of every one of the sixteen kinds with both fetch settings, and which fault wins when a second one follows. They also include the case where a fault and insn_done come in the same cycle, an acknowledge that arrives with nothing to accept, and insensitivity to the unused middle bits.

// File: rtl/memfault_pkg.sv
package memfault_pkg;

  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    FK_NONE        = 4'd0,
    FK_ALIGN       = 4'd1,
    FK_RESERVED    = 4'd2,
    FK_EXTERNAL    = 4'd3,
    FK_SEC_LFETCH  = 4'd4,
    FK_SEC_XLATE   = 4'd5,
    FK_PG_LFETCH   = 4'd6,
    FK_PG_XLATE    = 4'd7,
    FK_SEC_BUS     = 4'd8,
    FK_SEC_DOMAIN  = 4'd9,
    FK_PG_BUS      = 4'd10,
    FK_PG_DOMAIN   = 4'd11,
    FK_L1_BUS      = 4'd12,
    FK_SEC_PERM    = 4'd13,
    FK_L2_BUS      = 4'd14,
    FK_PG_PERM     = 4'd15
  } fault_kind_e;

  // Any kind other than "none" is a real fault and leads to an abort.
  function automatic logic kind_is_fault(fault_kind_e k);
    return k != FK_NONE;
  endfunction

  // External errors are aborted but never written to the registers.
  function automatic logic kind_is_recorded(fault_kind_e k);
    return (k != FK_NONE) && (k != FK_EXTERNAL);
  endfunction

endpackage

// File: rtl/memfault_decode.sv
module memfault_decode
  import memfault_pkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int DOM_W    = 4,
  parameter int ADDR_LSB = 32,
  parameter int ADDR_W   = 32,
  localparam int STAT_W  = KIND_W + DOM_W
) (
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  input  logic              fetch,
  output logic              data_hit,
  output logic              rec_hit,
  output logic              fetch_hit,
  output logic [STAT_W-1:0] stat_field,
  output logic [ADDR_W-1:0] addr_field
);

  fault_kind_e kind;
  logic        unused_mid;

  assign kind       = fault_kind_e'(word[KIND_W-1:0]);
  assign stat_field = word[STAT_W-1:0];
  assign addr_field = word[ADDR_LSB +: ADDR_W];
  assign unused_mid = ^word[ADDR_LSB-1:STAT_W];

  assign data_hit  = valid && !fetch && kind_is_fault(kind);
  assign rec_hit   = valid && !fetch && kind_is_recorded(kind);
  assign fetch_hit = valid && fetch;

endmodule

// File: rtl/memfault_regs.sv
module memfault_regs #(
  parameter int STAT_W = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] stat_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [STAT_W-1:0] stat_q,
  output logic [ADDR_W-1:0] addr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      addr_q <= '0;
    end else if (wr_en) begin
      stat_q <= stat_in;
      addr_q <= addr_in;
    end
  end

endmodule

// File: rtl/memfault_abort_seq.sv
module memfault_abort_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic data_hit,
  input  logic insn_done,
  input  logic abort_ack,
  output logic pend_q,
  output logic req_q,
  output logic ack_fire
);

  logic pend_d, req_d, pend_eff;

  assign ack_fire = abort_ack && req_q;
  // Pending as seen by this cycle's instruction end.
  assign pend_eff = ack_fire ? data_hit : (pend_q || data_hit);
  assign pend_d   = pend_eff;
  assign req_d    = ack_fire ? (data_hit && insn_done)
                             : (req_q || (pend_eff && insn_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      req_q  <= req_d;
    end
  end

  p_req_has_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> pend_q);

  p_req_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(insn_done));

endmodule

// File: rtl/memfault_capture.sv
module memfault_capture
  import memfault_pkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int DOM_W    = 4,
  parameter int ADDR_LSB = 32,
  parameter int ADDR_W   = 32,
  localparam int STAT_W  = KIND_W + DOM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_valid,
  input  logic [WORD_W-1:0] flt_word,
  input  logic              flt_fetch,
  input  logic              insn_done,
  input  logic              abort_ack,
  output logic              abort_pending,
  output logic              abort_req,
  output logic              prefetch_abort,
  output logic [STAT_W-1:0] fault_status,
  output logic [ADDR_W-1:0] fault_addr
);

  logic              data_hit, rec_hit, fetch_hit, ack_fire, cap_en;
  logic [STAT_W-1:0] stat_field;
  logic [ADDR_W-1:0] addr_field;
  logic              pf_q;

  memfault_decode #(
    .WORD_W(WORD_W), .DOM_W(DOM_W), .ADDR_LSB(ADDR_LSB), .ADDR_W(ADDR_W)
  ) dec_i (
    .valid(flt_valid), .word(flt_word), .fetch(flt_fetch),
    .data_hit(data_hit), .rec_hit(rec_hit), .fetch_hit(fetch_hit),
    .stat_field(stat_field), .addr_field(addr_field)
  );

  memfault_abort_seq seq_i (
    .clk(clk), .rst_n(rst_n), .data_hit(data_hit), .insn_done(insn_done),
    .abort_ack(abort_ack), .pend_q(abort_pending), .req_q(abort_req),
    .ack_fire(ack_fire)
  );

  // First recordable fault wins; acceptance reopens the registers.
  assign cap_en = rec_hit && (!abort_pending || ack_fire);

  memfault_regs #(.STAT_W(STAT_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cap_en),
    .stat_in(stat_field), .addr_in(addr_field),
    .stat_q(fault_status), .addr_q(fault_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pf_q <= 1'b0;
    else        pf_q <= fetch_hit;
  end
  assign prefetch_abort = pf_q;

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (fault_status == $past(flt_word[STAT_W-1:0]))
            && (fault_addr == $past(flt_word[ADDR_LSB +: ADDR_W])));

  p_ext_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_fetch && flt_word[KIND_W-1:0] == FK_EXTERNAL)
      |=> $stable(fault_status) && $stable(fault_addr) && abort_pending);

  p_fetch_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_fetch) |=> $stable(fault_status) && $stable(fault_addr)
                                 && prefetch_abort);

  p_pf_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(flt_valid && flt_fetch) |=> !prefetch_abort);

  p_none_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort_pending && !(flt_valid && !flt_fetch && flt_word[KIND_W-1:0] != FK_NONE))
      |=> !abort_pending);

  p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pending && !(abort_ack && abort_req))
      |=> $stable(fault_status) && $stable(fault_addr));

  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req && abort_ack && !flt_valid) |=> !abort_pending && !abort_req);

endmodule

// File: tb/memfault_capture_tb_top.sv
module memfault_capture_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_valid = 1'b0;
  logic [63:0] flt_word = '0;
  logic        flt_fetch = 1'b0;
  logic        insn_done = 1'b0;
  logic        abort_ack = 1'b0;
  logic        abort_pending, abort_req, prefetch_abort;
  logic [7:0]  fault_status;
  logic [31:0] fault_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  logic [7:0]  m_stat = '0;
  logic [31:0] m_addr = '0;
  logic        m_pend = 0, m_req = 0, m_pf = 0;

  always #5 clk = ~clk;

  memfault_capture dut_i (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_word(flt_word),
    .flt_fetch(flt_fetch), .insn_done(insn_done), .abort_ack(abort_ack),
    .abort_pending(abort_pending), .abort_req(abort_req),
    .prefetch_abort(prefetch_abort), .fault_status(fault_status),
    .fault_addr(fault_addr)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "fault_status", 32'(fault_status), 32'(m_stat));
    chk(tag, "fault_addr", fault_addr, m_addr);
    chk(tag, "abort_pending", 32'(abort_pending), 32'(m_pend));
    chk(tag, "abort_req", 32'(abort_req), 32'(m_req));
    chk(tag, "prefetch_abort", 32'(prefetch_abort), 32'(m_pf));
  endtask

  // Drive one cycle at the falling edge, predict, check at the next falling edge.
  task automatic step(logic v, logic [63:0] w, logic f, logic dn, logic ak, string tag);
    logic ack_ok, data, rec, pend_eff;
    flt_valid = v; flt_word = w; flt_fetch = f; insn_done = dn; abort_ack = ak;
    ack_ok   = ak && m_req;
    data     = v && !f && (w[3:0] != 4'd0);
    rec      = data && (w[3:0] != 4'd3) && (!m_pend || ack_ok);
    pend_eff = ack_ok ? data : (m_pend || data);
    if (rec) begin m_stat = w[7:0]; m_addr = w[63:32]; end
    m_req  = ack_ok ? (data && dn) : (m_req || (pend_eff && dn));
    m_pend = pend_eff;
    m_pf   = v && f;
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  function automatic logic [63:0] mk(logic [3:0] kind, logic [3:0] dom,
                                     logic [31:0] va, logic [23:0] mid);
    return {va, mid, dom, kind};
  endfunction

  initial begin
    #2_000_000;
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1");                      // outputs during reset
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");                      // after release

    // Sweep: every kind, both fetch settings.
    for (int t = 0; t < 16; t++) begin
      for (int f = 0; f < 2; f++) begin
        logic [63:0] w1, w2;
        string tg;
        w1 = mk(4'(t), 4'((t * 7 + 3) & 15), 32'hA000_0000 + 32'(t * 64 + f),
                24'h5A5A5A);
        w2 = mk(4'd5, 4'hE, 32'h1234_0000 + 32'(t), 24'h0);
        tg = f ? "R4" : (t == 0 ? "R5" : (t == 3 ? "R3" : "R2"));
        step(1'b1, w1, f[0], 1'b0, 1'b0, tg);
        step(1'b1, w2, 1'b0, 1'b0, 1'b0, "R7");   // locked if first was data
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, "R6");   // no request before done
        step(1'b0, '0, 1'b0, 1'b1, 1'b0, "R6");   // instruction ends
        step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R8");   // accepted
      end
    end

    // Fault and instruction end in the same cycle.
    step(1'b1, mk(4'd13, 4'h2, 32'hCAFE_0000, 24'h0), 1'b0, 1'b1, 1'b0, "R6");
    // Acknowledge together with a new data fault: new fault is recorded.
    step(1'b1, mk(4'd9, 4'h6, 32'hBEEF_0040, 24'h0), 1'b0, 1'b0, 1'b1, "R8");
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, "R8");
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R8");
    // Acknowledge with no request is ignored.
    step(1'b1, mk(4'd7, 4'h1, 32'h0000_1000, 24'h0), 1'b0, 1'b0, 1'b0, "R2");
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R8");
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, "R6");
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R8");
    // Instruction end before the fault does not raise the request.
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, "R6");
    step(1'b1, mk(4'd1, 4'h0, 32'h0000_0003, 24'h0), 1'b0, 1'b0, 1'b0, "R6");
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, "R6");
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R8");
    // Middle bits ignored: two words differing only in 31:8.
    for (int k = 0; k < 2; k++) begin
      step(1'b1, mk(4'd15, 4'hA, 32'h7777_0000, k ? 24'hFFFFFF : 24'h000000),
           1'b0, 1'b1, 1'b0, "R9");
      chk("R9", "fault_status", 32'(fault_status), 32'h0000_00AF);
      step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R9");
    end
    // External error while idle keeps earlier record.
    step(1'b1, mk(4'd3, 4'h4, 32'hDEAD_0000, 24'h0), 1'b0, 1'b0, 1'b0, "R3");
    chk("R3", "fault_addr", fault_addr, 32'h7777_0000);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, "R3");
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R3");

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule